// File: doc/BRIEF.md
# Lockable flash timing clock divider

This block holds the control register that sets the timing reference for program and erase steps in an embedded flash controller. It also holds the prescaler that divides the bus clock down to a timing tick of about 1 MHz. Software writes a divider value over a simple register bus. It can freeze that value with a write-once lock bit. A flag, which software cannot write, records whether the register has been written since reset.

Two inputs control when writes are accepted. A special-mode input lets every field except the flag be rewritten at any time, and this includes clearing the lock. A command-busy input blocks all writes while a flash command is running. The tick output pulses once every divider-plus-one bus clocks, and only after the register has been written.

Top module: `flash_tick_divider`

## Requirements
- R1: After a synchronous reset, a read returns 0x00 and the tick output is low.
- R2: Bit 7 is the loaded flag. It reads 0 until the first accepted write and 1 from then on, whatever value is written to bit 7. No write can clear it.
- R3: In normal mode, bit 6 is the lock. Once it reads 1, normal-mode writes change neither the lock nor the divider field in bits 5..0.
- R4: In normal mode with the lock at 0, a write loads bits 5..0 into the divider field and bit 6 into the lock. This can be repeated any number of times.
- R5: In special mode, every write loads bits 6..0, whatever the lock state. This includes writing the lock back to 0.
- R6: A write presented while cmd_busy is high is ignored completely. The loaded flag, the lock and the divider field all keep their values.
- R7: With a divider value D loaded, tick is high for exactly one cycle in every D+1 cycles. With D = 0, tick is high on every cycle.
- R8: Tick stays low while the loaded flag is 0.
- R9: A write that loads the divider field restarts the prescaler. The first tick is sampled high D+1 cycles after the write edge, and none comes earlier.
- R10: rd_data shows the register value captured on the clock edge where rd_en is high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | High selects special mode, in which the lock is bypassed |
| cmd_busy | input | 1 | High while a flash command is running; writes are blocked |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data |
| tick | output | 1 | Single-cycle timing tick |

## Verification
The bench builds the block with its default 6-bit divider field. This is small enough to sweep all 64 divider values, from the continuous tick at 0 up to a ratio of 64. For each value it checks the first tick after the write and the tick at the second period. The narrow register also makes it practical to walk the lock through every mode and busy combination, and to check each outcome by reading the register back.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
  // Outcome of a write presented on the register bus
  typedef enum logic [1:0] {
    WR_NONE      = 2'd0,  // no write, or blocked by a running command
    WR_FLAG_ONLY = 2'd1,  // locked normal-mode write: only marks the register written
    WR_FULL      = 2'd2   // lock and divider field are loaded
  } wr_kind_e;
endpackage

// File: rtl/tdiv_cfg_reg.sv
module tdiv_cfg_reg
  import tdiv_pkg::*;
#(
  parameter int DIV_W = 6,
  localparam int REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             cmd_busy,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             loaded,
  output logic             lock,
  output logic [DIV_W-1:0] div_q,
  output logic             div_wr
);
  wr_kind_e kind;

  always_comb begin
    kind = WR_NONE;
    if (wr_en && !cmd_busy) begin
      if (special_mode || !lock) kind = WR_FULL;
      else                       kind = WR_FLAG_ONLY;
    end
  end

  assign div_wr = (kind == WR_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= 1'b0;
      lock   <= 1'b0;
      div_q  <= '0;
    end else if (kind != WR_NONE) begin
      loaded <= 1'b1;
      if (kind == WR_FULL) begin
        lock  <= wr_data[DIV_W];
        div_q <= wr_data[DIV_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tdiv_prescaler.sv
module tdiv_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider #(
  parameter int DIV_W = 6,
  localparam int REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             cmd_busy,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output logic             tick
);
  logic             loaded;
  logic             lock;
  logic [DIV_W-1:0] div_q;
  logic             div_wr;

  tdiv_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .special_mode (special_mode),
    .cmd_busy     (cmd_busy),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .loaded       (loaded),
    .lock         (lock),
    .div_q        (div_q),
    .div_wr       (div_wr)
  );

  tdiv_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .enable  (loaded),
    .restart (div_wr),
    .div     (div_q),
    .tick    (tick)
  );

  // Registered read port: captures the current register image on a read strobe
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {loaded, lock, div_q};
  end
endmodule

// File: rtl/tdiv_checker.sv
module tdiv_checker #(
  parameter int DIV_W = 6,
  localparam int REG_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             special_mode,
  input logic             cmd_busy,
  input logic [REG_W-1:0] rd_data,
  input logic             tick,
  input logic             loaded,
  input logic             lock,
  input logic [DIV_W-1:0] div_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && !tick); // R1

  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (rst)
    loaded |=> loaded); // R2

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!special_mode && lock) |=> lock); // R3

  AST_LOCK_FREEZES_DIV: assert property (@(posedge clk) disable iff (rst)
    (!special_mode && lock) |=> $stable(div_q)); // R3

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |=> ($stable(loaded) && $stable(lock) && $stable(div_q))); // R6

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (tick && div_q != '0) |=> !tick); // R7

  AST_NO_TICK_UNLOADED: assert property (@(posedge clk) disable iff (rst)
    !loaded |-> !tick); // R8
endmodule

bind flash_tick_divider tdiv_checker #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .special_mode (special_mode),
  .cmd_busy     (cmd_busy),
  .rd_data      (rd_data),
  .tick         (tick),
  .loaded       (loaded),
  .lock         (lock),
  .div_q        (div_q)
);

// File: tb/tb_flash_tick_divider.sv
`timescale 1ns/1ps
module tb_flash_tick_divider;
  localparam int DIV_W = 6;
  localparam int REG_W = DIV_W + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             special_mode = 1'b0;
  logic             cmd_busy = 1'b0;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [REG_W-1:0] rd_data;
  logic             tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_tick_divider #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .special_mode(special_mode), .cmd_busy(cmd_busy),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tick(tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One write cycle; returns at the negedge just after the write edge
  task automatic do_write(input logic [REG_W-1:0] d, input logic spec, input logic busy);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; special_mode = spec; cmd_busy = busy;
    @(negedge clk);
    wr_en = 1'b0; cmd_busy = 1'b0;
  endtask

  task automatic do_read(input string req, input int exp);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, int'(rd_data), exp);
  endtask

  // Called right after do_write: tick after edge n must equal (n mod (D+1) == 0)
  task automatic check_ticks(input string req, input int d);
    int bad = 0;
    for (int n = 1; n <= 2 * (d + 1); n++) begin
      @(negedge clk);
      if (tick !== ((n % (d + 1)) == 0)) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic expect_no_tick(input string req, input int cycles);
    int seen = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 tick after reset", int'(tick), 0);
    do_read("R1 reset read", 8'h00);
    expect_no_tick("R8 idle before write", 20);

    // Busy write from reset: nothing changes, not even the flag
    do_write(8'h43, 1'b0, 1'b1);
    expect_no_tick("R8 no tick after blocked write", 20);
    do_read("R6 blocked write from reset", 8'h00);

    // Normal unlocked writes; bit 7 of the data is irrelevant
    do_write(8'h03, 1'b0, 1'b0);
    check_ticks("R9 first tick after write D=3", 3);
    do_read("R2 R4 first normal write", 8'h83);
    do_write(8'h05, 1'b0, 1'b0);
    do_read("R4 rewrite while unlocked", 8'h85);
    do_write(8'h00, 1'b1, 1'b0);
    do_read("R2 flag survives write of 0", 8'h80);

    // Exhaustive divider sweep in special mode
    for (int d = 0; d < (1 << DIV_W); d++) begin
      do_write(REG_W'(((d & 1) << 7) | d), 1'b1, 1'b0);
      check_ticks("R7 tick ratio D+1", d);
      do_read("R5 special write readback", 8'h80 | d);
    end

    // Restart on rewrite mid-period
    do_write(8'h09, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    do_write(8'h09, 1'b1, 1'b0);
    check_ticks("R9 restart on rewrite", 9);

    // Lock in normal mode
    do_write(8'h47, 1'b0, 1'b0);
    do_read("R3 lock set", 8'hC7);
    do_write(8'h02, 1'b0, 1'b0);
    do_read("R3 locked write ignored", 8'hC7);
    do_write(8'h81, 1'b0, 1'b0);
    do_read("R3 locked write ignored again", 8'hC7);

    // Busy write in special mode is still ignored
    do_write(8'h05, 1'b1, 1'b1);
    do_read("R6 busy special write ignored", 8'hC7);

    // Special mode clears the lock
    do_write(8'h05, 1'b1, 1'b0);
    do_read("R5 lock cleared in special", 8'h85);
    do_write(8'h01, 1'b0, 1'b0);
    do_read("R4 normal write after unlock", 8'h81);

    // Read data holds between strobes
    do_write(8'h0C, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 rd_data holds old value", int'(rd_data), 8'h81);
    do_read("R10 fresh read", 8'h8C);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule